// File: doc/BRIEF.md
# Three-wire serial slave shifter with echo

This block is the slave end of a three-wire synchronous serial link. An external master supplies the shift clock and an active-low select. The block moves one word out on its serial output and takes one word in on its serial input in each frame. A host port with three word addresses gives software control over the link. Through it software loads the outgoing word, reads the incoming word, picks the frame length (8 or 16 bits) and turns on echo. It also reads the status flags and acknowledges them.

All three serial inputs pass through two-flop synchronisers into the system clock. Shift-clock edges are then found by comparing successive synchronised samples. The input is sampled on a rising edge and the output moves after a falling edge. When software has not loaded a fresh word since the last frame began and echo is on, the block returns each received bit on its output. Three status flags are each gated by their own enable and combined into one interrupt line: idle, read-buffer-full and overrun.

Top module: `mwire_slave`

Host map: address 0 is data (a write loads the transmit word, a read returns the receive buffer). Address 1 is control: bit 0 selects 16-bit frames, bit 1 enables echo, bits 2/3/4 enable the idle, buffer-full and overrun interrupts. Address 2 is status: bit 0 busy, bit 1 buffer full, bit 2 overrun.

## Requirements
- R1: `sdo_en_o` is low while the select is high (inactive) and goes high once the synchronised select is low.
- R2: The transmit word goes out MSB first, one bit per shift clock. In 8-bit mode (control bit 0 = 0) the bits sent are data[7:0]; in 16-bit mode they are data[15:0]. The first bit is on `sdo_o` before the first rising edge, and each later bit appears after a falling edge.
- R3: After 8 (8-bit mode) or 16 (16-bit mode) rising edges, the bits sampled on `sdi_i` go into the receive buffer MSB first. An 8-bit word is zero-extended. Status bit 1 (buffer full) is then set.
- R4: With echo on (control bit 1), in a frame that starts with no host write to address 0 since the previous frame start, each sampled input bit is driven on `sdo_o` after the next falling edge. The received word is still stored.
- R5: With echo off, a frame that starts with no fresh write sends the last written word again.
- R6: Raising the select returns the bit counter to zero. A partial frame is dropped and does not set buffer full.
- R7: Status bit 0 (busy) is 1 from the first rising edge of a frame until that frame completes or the select is raised.
- R8: A host read of address 0 clears buffer full.
- R9: A frame that completes while buffer full is still set sets status bit 2 (overrun). The new word is discarded and the buffer keeps its old word. Writing 1 to status bit 2 clears overrun.
- R10: `irq_o` = (not busy AND control bit 2) OR (buffer full AND control bit 3) OR (overrun AND control bit 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (needed for the clear-on-read of address 0) |
| host_addr | input | 2 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational from the address |
| sclk_i | input | 1 | Shift clock from the master |
| cs_n_i | input | 1 | Active-low select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Output enable for the serial output driver |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that each shift-clock level and each select level lasts several system clocks, so that no edge is lost in the synchronisers. They also assume that `sdi_i` only changes while the shift clock is low. The bench holds each clock phase for six system cycles. It changes the serial input only together with a falling shift-clock edge, and it changes the frame mode only while no frame is in progress.

// File: rtl/mwire_slave.sv
module mwire_slave (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [1:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        sclk_i,
  input  logic        cs_n_i,
  input  logic        sdi_i,
  output logic        sdo_o,
  output logic        sdo_en_o,
  output logic        irq_o
);
  logic [2:0]  sclk_q;
  logic [1:0]  cs_q, sdi_q;
  logic [4:0]  ctl_q;
  logic [15:0] txd_q, tsh_q, rsh_q, rbuf_q;
  logic [3:0]  cnt_q;
  logic        txv_q, f16_q, fecho_q, echo_bit_q, rbf_q, ovr_q;

  logic sel, rise, fall, sbit, idle, m16, echo_now, done, rd_clr;
  logic [3:0]  last;
  logic [15:0] rx_word, rx_ext;

  assign sel  = ~cs_q[1];
  assign rise = sel & sclk_q[1] & ~sclk_q[2];
  assign fall = sel & ~sclk_q[1] & sclk_q[2];
  assign sbit = sdi_q[1];
  assign idle = (cnt_q == 4'd0);
  assign m16  = idle ? ctl_q[0] : f16_q;
  assign echo_now = idle ? (ctl_q[1] & ~txv_q) : fecho_q;
  assign last = m16 ? 4'd15 : 4'd7;
  assign done = rise & (cnt_q == last);
  assign rx_word = {rsh_q[14:0], sbit};
  assign rx_ext  = m16 ? rx_word : {8'h00, rx_word[7:0]};
  assign rd_clr  = host_rd & (host_addr == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= 2'b11;
      sdi_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk_i};
      cs_q   <= {cs_q[0], cs_n_i};
      sdi_q  <= {sdi_q[0], sdi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      txd_q <= '0;
      txv_q <= 1'b0;
    end else begin
      if (host_wr && host_addr == 2'd1) ctl_q <= host_wdata[4:0];
      if (host_wr && host_addr == 2'd0) begin
        txd_q <= host_wdata;
        txv_q <= 1'b1;
      end else if (rise && idle) begin
        txv_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      f16_q      <= 1'b0;
      fecho_q    <= 1'b0;
      tsh_q      <= '0;
      rsh_q      <= '0;
      echo_bit_q <= 1'b0;
    end else begin
      if (!sel)      cnt_q <= '0;
      else if (rise) cnt_q <= done ? 4'd0 : cnt_q + 4'd1;
      if (rise && idle) begin
        f16_q   <= ctl_q[0];
        fecho_q <= ctl_q[1] & ~txv_q;
      end
      if (idle)      tsh_q <= txd_q;
      else if (fall) tsh_q <= {tsh_q[14:0], 1'b0};
      if (rise)      rsh_q <= rx_word;
      if (fall)      echo_bit_q <= rsh_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf_q <= '0;
      rbf_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (done && rbf_q && !rd_clr) begin
        ovr_q <= 1'b1;
      end else begin
        if (host_wr && host_addr == 2'd2 && host_wdata[2]) ovr_q <= 1'b0;
        if (done) begin
          rbuf_q <= rx_ext;
          rbf_q  <= 1'b1;
        end else if (rd_clr) begin
          rbf_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = rbuf_q;
      2'd1:    host_rdata = {11'd0, ctl_q};
      2'd2:    host_rdata = {13'd0, ovr_q, rbf_q, ~idle};
      default: host_rdata = '0;
    endcase
  end

  assign sdo_en_o = sel;
  assign sdo_o    = echo_now ? echo_bit_q : (m16 ? tsh_q[15] : tsh_q[7]);
  assign irq_o    = (idle & ctl_q[2]) | (rbf_q & ctl_q[3]) | (ovr_q & ctl_q[4]);
endmodule

// File: rtl/mwire_slave_chk.sv
module mwire_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n_i,
  input logic        sdo_en_o,
  input logic        sel,
  input logic [3:0]  cnt_q,
  input logic        f16_q,
  input logic        host_rd,
  input logic [1:0]  host_addr,
  input logic        done,
  input logic        rbf_q,
  input logic        ovr_q,
  input logic [15:0] rbuf_q,
  input logic [4:0]  ctl_q,
  input logic        irq_o
);
  p_hiz_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2)) |-> !sdo_en_o);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != 4'd0) |-> (cnt_q <= (f16_q ? 4'd15 : 4'd7)));

  p_desel_resync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt_q == 4'd0));

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 2'd0 && !done) |=> !rbf_q);

  p_overrun_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> ($past(rbf_q) && $stable(rbuf_q)));

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[4:2] == 3'd0) |-> !irq_o);
endmodule

bind mwire_slave mwire_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sdo_en_o(sdo_en_o), .sel(sel),
  .cnt_q(cnt_q), .f16_q(f16_q), .host_rd(host_rd), .host_addr(host_addr),
  .done(done), .rbf_q(rbf_q), .ovr_q(ovr_q), .rbuf_q(rbuf_q), .ctl_q(ctl_q),
  .irq_o(irq_o)
);

// File: tb/mwire_slave_bench.sv
module mwire_slave_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0] host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic sclk_i = 1'b0, cs_n_i = 1'b1, sdi_i = 1'b0;
  logic sdo_o, sdo_en_o, irq_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mwire_slave u_mwire_slave (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic select(input logic on);
    @(negedge clk);
    cs_n_i = ~on;
    wait_n(6);
  endtask

  task automatic xfer(input int nb, input logic [15:0] din, output logic [15:0] dout);
    dout = '0;
    for (int i = 0; i < nb; i++) begin
      sclk_i = 1'b0;
      sdi_i = din[nb-1-i];
      wait_n(6);
      dout[nb-1-i] = sdo_o;
      sclk_i = 1'b1;
      wait_n(6);
    end
    sclk_i = 1'b0;
    wait_n(8);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 reset output enable", {15'd0, sdo_en_o}, 16'd0);
    chk("R10 reset irq", {15'd0, irq_o}, 16'd0);
    rd(2'd2, d);
    chk("R7 reset status", d, 16'd0);
  endtask

  task automatic t_byte;
    logic [15:0] d, o;
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h12A5);
    select(1'b1);
    chk("R1 enable when selected", {15'd0, sdo_en_o}, 16'd1);
    xfer(8, 16'h003C, o);
    chk("R2 8-bit tx", o, 16'h00A5);
    rd(2'd2, d);
    chk("R3 R7 status after 8-bit frame", d, 16'h0002);
    rd(2'd0, d);
    chk("R3 8-bit rx", d, 16'h003C);
    rd(2'd2, d);
    chk("R8 read clears full", d, 16'h0000);
    select(1'b0);
    chk("R1 disabled when deselected", {15'd0, sdo_en_o}, 16'd0);
  endtask

  task automatic t_word;
    logic [15:0] d, o;
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'hBEEF);
    select(1'b1);
    xfer(16, 16'h1234, o);
    chk("R2 16-bit tx", o, 16'hBEEF);
    rd(2'd0, d);
    chk("R3 16-bit rx", d, 16'h1234);
    select(1'b0);
  endtask

  task automatic t_echo;
    logic [15:0] d, o;
    wr(2'd1, 16'h0002);
    select(1'b1);
    xfer(8, 16'h00C6, o);
    chk("R4 echo bits", {9'd0, o[6:0]}, {9'd0, 7'h63});
    rd(2'd0, d);
    chk("R4 echo rx stored", d, 16'h00C6);
    select(1'b0);
  endtask

  task automatic t_stale;
    logic [15:0] d, o;
    wr(2'd1, 16'h0000);
    select(1'b1);
    xfer(8, 16'h0081, o);
    chk("R5 stale data sent", o, 16'h00EF);
    rd(2'd0, d);
    chk("R5 rx with stale tx", d, 16'h0081);
    select(1'b0);
  endtask

  task automatic t_resync;
    logic [15:0] d, o;
    wr(2'd0, 16'h005A);
    select(1'b1);
    xfer(3, 16'h0005, o);
    rd(2'd2, d);
    chk("R7 busy mid-frame", d, 16'h0001);
    select(1'b0);
    rd(2'd2, d);
    chk("R6 partial frame dropped", d, 16'h0000);
    wr(2'd0, 16'h0033);
    select(1'b1);
    xfer(8, 16'h0096, o);
    chk("R6 realigned tx", o, 16'h0033);
    rd(2'd0, d);
    chk("R6 realigned rx", d, 16'h0096);
    select(1'b0);
  endtask

  task automatic t_overrun;
    logic [15:0] d, o;
    select(1'b1);
    xfer(8, 16'h0011, o);
    xfer(8, 16'h0022, o);
    rd(2'd2, d);
    chk("R9 overrun flagged", d, 16'h0006);
    rd(2'd0, d);
    chk("R9 buffer kept", d, 16'h0011);
    wr(2'd2, 16'h0004);
    rd(2'd2, d);
    chk("R9 overrun cleared", d, 16'h0000);
    select(1'b0);
  endtask

  task automatic t_irq;
    logic [15:0] d, o;
    wr(2'd1, 16'h0004);
    wait_n(1);
    chk("R10 idle irq", {15'd0, irq_o}, 16'd1);
    wr(2'd1, 16'h0008);
    wait_n(1);
    chk("R10 full irq quiet", {15'd0, irq_o}, 16'd0);
    select(1'b1);
    xfer(8, 16'h0044, o);
    chk("R10 full irq", {15'd0, irq_o}, 16'd1);
    xfer(8, 16'h0055, o);
    wr(2'd1, 16'h0010);
    wait_n(1);
    chk("R10 overrun irq", {15'd0, irq_o}, 16'd1);
    wr(2'd2, 16'h0004);
    wait_n(1);
    chk("R10 overrun irq cleared", {15'd0, irq_o}, 16'd0);
    rd(2'd0, d);
    chk("R10 buffer before overrun", d, 16'h0044);
    select(1'b0);
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_byte();
    t_word();
    t_echo();
    t_stale();
    t_resync();
    t_overrun();
    t_irq();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule